// File: doc/BRIEF.md
# S/T-Line Multiframe Overhead Sequencer

This block sits on the network-termination side of a basic-rate S/T line. For every line frame it produces the four overhead bits: the framing-auxiliary bit, its companion balance bit, the multiframe marker bit and the S-channel bit. Frames are grouped in fives, and four groups form a 20-frame multiframe. The first frame of each group is marked by inverting the usual framing-auxiliary/companion pair. The first frame of the whole multiframe is also marked by the M bit. The S-channel bits are spread across the multiframe one bit per frame, interleaving five 4-bit subchannels.

In the other direction, the terminal sends its maintenance (Q) channel in the framing-auxiliary position of group-start frames only. The block samples that bit from the receive side and assembles a 4-bit Q word once per multiframe. A frame strobe advances the sequence by one frame. An enable starts and stops sequencing; the S-channel word is taken in at the start of every multiframe.

Top module: `mfs_tx_seq`

## Requirements
- R1: After reset, frame_num_o is 1, fa_o is 0, n_o is 1, m_o is 0, s_o is 0, mf_start_o is 0, q_valid_o is 0 and q_word_o is 0.
- R2: While en_i is low, the block is idle from the next clock edge: frame_num_o is 1, fa_o=0, n_o=1, m_o=0, s_o=0. Frame strobes have no effect, and any partly collected Q bits are discarded.
- R3: The first frame_i strobe seen with en_i high while idle starts frame 1 of a multiframe on the following cycle.
- R4: While enabled and running, each frame_i strobe advances frame_num_o by one, from 1 up to 20 and then back to 1. Without a strobe, frame_num_o holds.
- R5: On group-start frames (1, 6, 11, 16), fa_o=1 and n_o=0. On every other frame, and when idle, fa_o=0 and n_o=1.
- R6: m_o is 1 on frame 1 of a running multiframe and 0 otherwise.
- R7: On frame n, s_o carries bit b of subchannel k, where k=(n-1) mod 5 and b=(n-1) div 5 (both counted from 0). Subchannel k bit b is s_word_i[4k+b], so frames 1..5 send bit 0 of subchannels 0..4, and frame 20 sends s_word_i[19].
- R8: s_word_i is sampled only by the strobe that starts frame 1. Changes at any other time do not affect s_o until the next multiframe.
- R9: The rx_fa_i value present with the strobe that ends frames 1, 6, 11 and 16 becomes q_word_o bits 0, 1, 2 and 3. q_word_o is updated, and q_valid_o pulses for one cycle, in the cycle after the strobe that ends frame 16. At all other times q_word_o holds.
- R10: mf_start_o is a one-cycle pulse in the first cycle of each frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe at each line frame boundary |
| en_i | input | 1 | Multiframe sequencing enable |
| s_word_i | input | 20 | S-channel word, subchannel k bit b at index 4k+b |
| rx_fa_i | input | 1 | Received framing-auxiliary bit from the terminal, valid with frame_i |
| fa_o | output | 1 | Framing-auxiliary bit for the current frame |
| n_o | output | 1 | Companion balance bit for the current frame |
| m_o | output | 1 | Multiframe marker bit |
| s_o | output | 1 | S-channel bit for the current frame |
| mf_start_o | output | 1 | Pulse at the start of frame 1 |
| frame_num_o | output | 5 | Current frame number, 1 to 20 |
| q_word_o | output | 4 | Last assembled Q word, Q1 in bit 0 |
| q_valid_o | output | 1 | One-cycle pulse when q_word_o is updated |

## Verification
The hardest situations to reach are those where the multiframe is broken. One is disabling partway through the Q collection and then starting again; the other is changing the S word between two group boundaries. Directed sequences cover both. A full multiframe has its word replaced at frame 10 and a known Q pattern sent on the group-start frames. The random phase mostly keeps the enable high, but now and then drops it for a cycle. Strobe gaps are random, so wrap-around, mid-multiframe aborts and restarts all occur many times at arbitrary frame positions.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic [1:0] {
    FK_IDLE  = 2'd0,
    FK_GROUP = 2'd1,
    FK_PLAIN = 2'd2
  } frame_kind_e;

  // returns {fa, n}
  function automatic logic [1:0] fa_n_bits(frame_kind_e kind);
    case (kind)
      FK_GROUP: return 2'b10;
      default:  return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/mfs_frame_ctr.sv
module mfs_frame_ctr #(
  parameter int unsigned GROUP_LEN  = 5,
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned PW = (GROUP_LEN  > 1) ? $clog2(GROUP_LEN)  : 1,
  parameter int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          en_i,
  output logic          active_o,
  output logic [PW-1:0] pos_o,
  output logic [GW-1:0] grp_o,
  output logic          mf_begin_o,
  output logic          load_o
);
  localparam logic [PW-1:0] POS_LAST = PW'(GROUP_LEN - 1);
  localparam logic [GW-1:0] GRP_LAST = GW'(NUM_GROUPS - 1);

  logic          active_q, mfb_q;
  logic [PW-1:0] pos_q;
  logic [GW-1:0] grp_q;
  logic          at_end;

  assign at_end = (pos_q == POS_LAST) && (grp_q == GRP_LAST);
  // strobe that opens frame 1: word sample point
  assign load_o = en_i && frame_i && (!active_q || at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      grp_q    <= '0;
      mfb_q    <= 1'b0;
    end else begin
      mfb_q <= 1'b0;
      if (!en_i) begin
        active_q <= 1'b0;
        pos_q    <= '0;
        grp_q    <= '0;
      end else if (frame_i) begin
        if (!active_q) begin
          active_q <= 1'b1;
          pos_q    <= '0;
          grp_q    <= '0;
          mfb_q    <= 1'b1;
        end else if (pos_q == POS_LAST) begin
          pos_q <= '0;
          if (grp_q == GRP_LAST) begin
            grp_q <= '0;
            mfb_q <= 1'b1;
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign active_o   = active_q;
  assign pos_o      = pos_q;
  assign grp_o      = grp_q;
  assign mf_begin_o = mfb_q;
endmodule

// File: rtl/mfs_overhead.sv
module mfs_overhead
  import mfs_pkg::*;
#(
  parameter int unsigned GROUP_LEN  = 5,
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned PW = (GROUP_LEN  > 1) ? $clog2(GROUP_LEN)  : 1,
  parameter int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter int unsigned S_W = GROUP_LEN * NUM_GROUPS
) (
  input  logic           active_i,
  input  logic [PW-1:0]  pos_i,
  input  logic [GW-1:0]  grp_i,
  input  logic [S_W-1:0] s_word_i,
  output logic           fa_o,
  output logic           n_o,
  output logic           m_o,
  output logic           s_o
);
  // s_order[frame index] : frame f carries subchannel f%GL, bit f/GL
  logic [S_W-1:0] s_order;
  for (genvar k = 0; k < GROUP_LEN; k++) begin : g_sub
    for (genvar b = 0; b < NUM_GROUPS; b++) begin : g_bit
      assign s_order[b*GROUP_LEN + k] = s_word_i[k*NUM_GROUPS + b];
    end
  end

  frame_kind_e kind;
  int unsigned fidx;

  always_comb begin
    if (!active_i)          kind = FK_IDLE;
    else if (pos_i == '0)   kind = FK_GROUP;
    else                    kind = FK_PLAIN;
    fidx = int'(grp_i) * GROUP_LEN + int'(pos_i);
  end

  assign {fa_o, n_o} = fa_n_bits(kind);
  assign m_o = active_i && (pos_i == '0) && (grp_i == '0);
  assign s_o = active_i && s_order[fidx];
endmodule

// File: rtl/mfs_q_capture.sv
module mfs_q_capture #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  cap_i,
  input  logic [GW-1:0]         grp_i,
  input  logic                  rx_fa_i,
  output logic [NUM_GROUPS-1:0] q_word_o,
  output logic                  q_valid_o
);
  localparam logic [GW-1:0] GRP_LAST = GW'(NUM_GROUPS - 1);

  logic [NUM_GROUPS-1:0] acc_q, acc_nx, qw_q;
  logic                  qv_q, publish;

  always_comb begin
    acc_nx = acc_q;
    if (cap_i) acc_nx[grp_i] = rx_fa_i;
  end

  assign publish = cap_i && (grp_i == GRP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      qw_q  <= '0;
      qv_q  <= 1'b0;
    end else if (clear_i) begin
      acc_q <= '0;
      qv_q  <= 1'b0;
    end else begin
      acc_q <= acc_nx;
      qv_q  <= publish;
      if (publish) qw_q <= acc_nx;
    end
  end

  assign q_word_o  = qw_q;
  assign q_valid_o = qv_q;
endmodule

// File: rtl/mfs_tx_seq.sv
module mfs_tx_seq #(
  parameter int unsigned GROUP_LEN  = 5,
  parameter int unsigned NUM_GROUPS = 4,
  localparam int unsigned S_W  = GROUP_LEN * NUM_GROUPS,
  localparam int unsigned FN_W = $clog2(S_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_i,
  input  logic                  en_i,
  input  logic [S_W-1:0]        s_word_i,
  input  logic                  rx_fa_i,
  output logic                  fa_o,
  output logic                  n_o,
  output logic                  m_o,
  output logic                  s_o,
  output logic                  mf_start_o,
  output logic [FN_W-1:0]       frame_num_o,
  output logic [NUM_GROUPS-1:0] q_word_o,
  output logic                  q_valid_o
);
  localparam int unsigned PW = (GROUP_LEN  > 1) ? $clog2(GROUP_LEN)  : 1;
  localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic          active, load;
  logic [PW-1:0] pos;
  logic [GW-1:0] grp;
  logic [S_W-1:0] s_lat_q;

  mfs_frame_ctr #(.GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS), .PW(PW), .GW(GW)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .en_i       (en_i),
    .active_o   (active),
    .pos_o      (pos),
    .grp_o      (grp),
    .mf_begin_o (mf_start_o),
    .load_o     (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   s_lat_q <= '0;
    else if (load) s_lat_q <= s_word_i;
  end

  mfs_overhead #(.GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS), .PW(PW), .GW(GW), .S_W(S_W)) u_ovh (
    .active_i (active),
    .pos_i    (pos),
    .grp_i    (grp),
    .s_word_i (s_lat_q),
    .fa_o     (fa_o),
    .n_o      (n_o),
    .m_o      (m_o),
    .s_o      (s_o)
  );

  mfs_q_capture #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_qcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!en_i),
    .cap_i     (frame_i && en_i && active && (pos == '0)),
    .grp_i     (grp),
    .rx_fa_i   (rx_fa_i),
    .q_word_o  (q_word_o),
    .q_valid_o (q_valid_o)
  );

  assign frame_num_o = FN_W'(grp) * FN_W'(GROUP_LEN) + FN_W'(pos) + FN_W'(1);
endmodule

// File: rtl/mfs_tx_seq_chk.sv
module mfs_tx_seq_chk #(
  parameter int unsigned GROUP_LEN  = 5,
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned FN_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_i,
  input logic            en_i,
  input logic            fa_o,
  input logic            n_o,
  input logic            m_o,
  input logic            s_o,
  input logic            mf_start_o,
  input logic [FN_W-1:0] frame_num_o,
  input logic            q_valid_o
);
  localparam int unsigned S_W = GROUP_LEN * NUM_GROUPS;

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (frame_num_o == FN_W'(1) && !fa_o && n_o && !m_o && !s_o));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frame_i) |=> $stable(frame_num_o));

  p_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_num_o >= FN_W'(1)) && (int'(frame_num_o) <= S_W));

  p_group_fa_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fa_o |-> ((int'(frame_num_o) - 1) % GROUP_LEN == 0) && !n_o);

  p_marker_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_o |-> frame_num_o == FN_W'(1));

  p_qv_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> int'(frame_num_o) == (NUM_GROUPS - 1) * GROUP_LEN + 2);

  p_qv_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |=> !q_valid_o);

  p_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_o |-> (m_o && frame_num_o == FN_W'(1)));

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_o |=> !mf_start_o);
endmodule

bind mfs_tx_seq mfs_tx_seq_chk #(.GROUP_LEN(GROUP_LEN), .NUM_GROUPS(NUM_GROUPS), .FN_W(FN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame_i),
  .en_i        (en_i),
  .fa_o        (fa_o),
  .n_o         (n_o),
  .m_o         (m_o),
  .s_o         (s_o),
  .mf_start_o  (mf_start_o),
  .frame_num_o (frame_num_o),
  .q_valid_o   (q_valid_o)
);

// File: tb/tb_mfs_tx_seq.sv
`timescale 1ns/1ps
module tb_mfs_tx_seq;
  localparam int GL = 5;
  localparam int NG = 4;
  localparam int SW = GL * NG;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_i = 1'b0;
  logic          en_i = 1'b0;
  logic [SW-1:0] s_word_i = '0;
  logic          rx_fa_i = 1'b0;
  logic          fa_o, n_o, m_o, s_o, mf_start_o, q_valid_o;
  logic [4:0]    frame_num_o;
  logic [NG-1:0] q_word_o;

  always #4 clk_i = ~clk_i;

  mfs_tx_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .en_i(en_i),
    .s_word_i(s_word_i), .rx_fa_i(rx_fa_i), .fa_o(fa_o), .n_o(n_o),
    .m_o(m_o), .s_o(s_o), .mf_start_o(mf_start_o), .frame_num_o(frame_num_o),
    .q_word_o(q_word_o), .q_valid_o(q_valid_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_act = 1'b0;
  int          m_n = 1;
  logic [SW-1:0] m_lat = '0;
  logic [NG-1:0] m_acc = '0;
  logic [NG-1:0] m_q = '0;
  bit          m_qv = 1'b0;
  bit          m_mfb = 1'b0;

  function automatic bit exp_s(logic [SW-1:0] w, int n);
    return w[((n - 1) % GL) * NG + (n - 1) / GL];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit efa;
    efa = m_act && ((m_n - 1) % GL == 0);
    chk("R4", "frame_num", int'(frame_num_o), m_act ? m_n : 1);
    chk("R5", "fa", int'(fa_o), int'(efa));
    chk("R5", "n", int'(n_o), int'(!efa));
    chk("R6", "m", int'(m_o), int'(m_act && m_n == 1));
    chk("R7", "s", int'(s_o), m_act ? int'(exp_s(m_lat, m_n)) : 0);
    chk("R10", "mf_start", int'(mf_start_o), int'(m_mfb));
    chk("R9", "q_valid", int'(q_valid_o), int'(m_qv));
    chk("R9", "q_word", int'(q_word_o), int'(m_q));
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic step(bit fr, bit en, bit rx, logic [SW-1:0] w);
    frame_i = fr; en_i = en; rx_fa_i = rx; s_word_i = w;
    @(posedge clk_i);
    m_mfb = 1'b0; m_qv = 1'b0;
    if (!en) begin
      m_act = 1'b0; m_n = 1; m_acc = '0;
    end else if (fr) begin
      if (m_act) begin
        if ((m_n - 1) % GL == 0) begin
          m_acc[(m_n - 1) / GL] = rx;
          if (m_n == (NG - 1) * GL + 1) begin
            m_q = m_acc; m_qv = 1'b1;
          end
        end
        m_n = (m_n == SW) ? 1 : m_n + 1;
        if (m_n == 1) begin m_lat = w; m_mfb = 1'b1; end
      end else begin
        m_act = 1'b1; m_n = 1; m_lat = w; m_mfb = 1'b1;
      end
    end
    @(negedge clk_i);
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] w_old, w_new, w_cur;
    logic [NG-1:0] qpat;
    void'($urandom(32'd4711));

    #10;
    // R1 reset state
    chk("R1", "frame_num", int'(frame_num_o), 1);
    chk("R1", "fa", int'(fa_o), 0);
    chk("R1", "n", int'(n_o), 1);
    chk("R1", "m", int'(m_o), 0);
    chk("R1", "s", int'(s_o), 0);
    chk("R1", "mf_start", int'(mf_start_o), 0);
    chk("R1", "q_valid", int'(q_valid_o), 0);
    chk("R1", "q_word", int'(q_word_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: strobes while disabled do nothing
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, 1'b1, '1);
      chk("R2", "idle frame_num", int'(frame_num_o), 1);
      chk("R2", "idle s", int'(s_o), 0);
    end

    // R3: first enabled strobe starts frame 1
    w_old = 20'hA5C3E;
    w_new = ~w_old;
    qpat  = 4'b1011;
    step(1'b0, 1'b1, 1'b0, w_old);
    chk("R3", "no start without strobe", int'(frame_num_o), 1);
    chk("R3", "m before strobe", int'(m_o), 0);
    step(1'b1, 1'b1, 1'b0, w_old);
    chk("R3", "started m", int'(m_o), 1);
    chk("R3", "started mf_start", int'(mf_start_o), 1);
    step(1'b0, 1'b1, 1'b0, w_old);
    chk("R10", "pulse width", int'(mf_start_o), 0);

    // full multiframe, word replaced mid-way (R8), Q pattern (R9)
    for (int n = 1; n <= SW; n++) begin
      bit rx;
      rx = ((n - 1) % GL == 0) ? qpat[(n - 1) / GL] : 1'($urandom);
      w_cur = (n >= 10) ? w_new : w_old;
      step(1'b1, 1'b1, rx, w_cur);
      if (n >= 10 && n < SW)
        chk("R8", "s keeps old word", int'(s_o), int'(exp_s(w_old, n + 1)));
      if (n == (NG - 1) * GL + 1) begin
        chk("R9", "q word", int'(q_word_o), int'(qpat));
        chk("R9", "q pulse", int'(q_valid_o), 1);
      end
      if (n == SW)
        chk("R8", "new word at frame 1", int'(s_o), int'(exp_s(w_new, 1)));
      step(1'b0, 1'b1, 1'b0, w_old);
    end

    // R2: abort mid multiframe
    for (int n = 0; n < 7; n++) step(1'b1, 1'b1, 1'b1, w_new);
    step(1'b0, 1'b0, 1'b0, w_new);
    chk("R2", "abort frame_num", int'(frame_num_o), 1);
    chk("R2", "abort fa", int'(fa_o), 0);

    // random phase
    w_cur = 20'($urandom);
    for (int i = 0; i < 4000; i++) begin
      bit en, fr, rx;
      en = ($urandom % 60) != 0;
      fr = ($urandom % 3) == 0;
      rx = 1'($urandom);
      if (($urandom % 25) == 0) w_cur = 20'($urandom);
      step(fr, en, rx, w_cur);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule